// File: doc/BRIEF.md
# Triangular Spread-Spectrum Divider Modulator

This block produces, for each of two clock groups, a fixed-point effective divider word. The word follows a slow triangular sweep around a programmable base value N. A fractional feedback divider or a numerically controlled oscillator consumes the word, which spreads that group's clock energy over a narrow band. A 3-bit magnitude code per group picks either a down-spread profile or a centre-spread profile and sets its size. One shared enable turns spreading on for both groups. Each group keeps its own sweep position, so the two groups sweep independently.

The sweep is built from equal steps. Each step lasts `STEP_CYCLES` system clocks, and a full triangle takes `4 * 2^QLOG2` steps. With a 100 MHz system clock and the default parameters, the triangle period is 32 µs, which places the modulation rate near 31 kHz. A new enable value or a new magnitude code takes effect only when the sweep sits at zero offset, so the word never jumps. The base N is applied one clock after it is presented, whether or not a sweep is running.

The output word carries `FRAC_W` fraction bits. `UNIT` is the fixed-point value of a 0.125 % offset, and its default of 20972 is the value 2^24 / 800 rounded. The sweep level L runs in steps of one.

Top module: `ssc_dual`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge every group shows `eff_div_o` = 0, `spread_on_o` = 0, `at_zero_o` = 1 and `sweep_up_o` = 1.
- R2: While a group is idle (`spread_on_o` = 0), its `eff_div_o` equals N·2^FRAC_W, its `at_zero_o` is 1, and its active code is reloaded from `mag_code_i` on every clock.
- R3: A magnitude code with bit 2 = 0 selects down spread, with multiplier k = code[1:0]+1. Codes 0 to 3 give 0.25 %, 0.5 %, 0.75 % and 1 %. The level L starts at 0, falls to −2·2^QLOG2 and rises back to 0. `eff_div_o` never exceeds N·2^FRAC_W, and its minimum is N·2^FRAC_W − 2·N·k·UNIT.
- R4: A magnitude code with bit 2 = 1 selects centre spread, with k = code[1:0]+1. Codes 4 to 7 give ±0.125 %, ±0.25 %, ±0.375 % and ±0.5 %. L starts at 0, rises to +2^QLOG2, falls to −2^QLOG2 and returns to 0, so `eff_div_o` spans N·2^FRAC_W ± N·k·UNIT.
- R5: While active, L changes by exactly ±1 once every `STEP_CYCLES` clocks, so one triangle lasts 4·2^QLOG2·STEP_CYCLES clocks. `eff_div_o` = N·2^FRAC_W + floor(N·L·k·UNIT / 2^QLOG2), and it equals the nominal value whenever `at_zero_o` = 1.
- R6: A change of `mag_code_i` while a group is away from zero has no effect until L next returns to 0. The new code is taken on the step that lands on 0.
- R7: `spread_en_i` is taken when idle, on the next clock edge. While active, it is taken only on a step that lands L on 0. A group stops (`spread_on_o` falls) only with `at_zero_o` = 1, and it starts only at zero offset.
- R8: `sweep_up_o` = 1 means the offset is moving upward. A down-spread group starts with 0, and a centre-spread group starts with 1.
- R9: A change of a group's `base_n_i` appears in `eff_div_o` after the next clock edge, whether the group is active or idle.
- R10: The groups use separate codes, bases and sweep state. The profile and extremes of one group do not depend on the other group's code or base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spread_en_i | input | 1 | Shared spread enable for all groups |
| mag_code_i | input | 3·GROUPS | Magnitude code per group, group g at bits [3g+2:3g] |
| base_n_i | input | N_W·GROUPS | Base divider N per group, group g at bits [N_W·g +: N_W] |
| eff_div_o | output | (N_W+1+FRAC_W)·GROUPS | Effective divider word per group, unsigned, FRAC_W fraction bits |
| spread_on_o | output | GROUPS | Group is currently sweeping |
| sweep_up_o | output | GROUPS | Offset direction: 1 = rising |
| at_zero_o | output | GROUPS | Sweep level is at zero offset |

## Verification
Every output is a function of registers only. A change of N therefore shows one edge later. A change of enable while idle shows on the next edge. A sweep step shows on the edge where the `STEP_CYCLES`-th active clock completes. A code or enable change made mid-sweep shows first on the step that lands on zero, which can be up to a full triangle later. The bench drives inputs just after a rising edge and compares every output with its behavioural model at the falling edge. Its extreme-value and step-count checks use windows aligned to whole triangle periods, counted from the edge on which the enable was taken.

// File: rtl/ssc_pkg.sv
// Shared helpers for the triangular spread-spectrum modulator.
// Assumes magnitude codes are 3 bits: bit 2 picks the profile, bits 1:0 the size.
package ssc_pkg;

    // Profile selected by bit 2 of the magnitude code.
    typedef enum logic {
        PROF_DOWN   = 1'b0,
        PROF_CENTER = 1'b1
    } ssc_prof_e;

    // Decode the profile from a magnitude code.
    function automatic ssc_prof_e code_profile(input logic [2:0] code);
        return ssc_prof_e'(code[2]);
    endfunction

    // Size multiplier k = code[1:0] + 1 (1..4 unit steps of 0.125 %).
    function automatic logic [2:0] code_mult(input logic [2:0] code);
        return {1'b0, code[1:0]} + 3'd1;
    endfunction

endpackage

// File: rtl/ssc_step_timer.sv
// Step timer: raises a one-cycle step strobe every STEP_CYCLES clocks while run is high.
// Assumes STEP_CYCLES >= 1; the count restarts from zero whenever run is low.
module ssc_step_timer #(
    parameter int STEP_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step
);
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count clocks within one step; hold at zero while the sweep is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign step = run && (cnt == LAST);

endmodule

// File: rtl/ssc_tri_walker.sv
// Triangle walker: holds the signed sweep level, its direction and the active
// enable/code. New enable/code values are loaded only while idle or on a step
// that lands the level on zero.
// Assumes level is in units of 1/2^QLOG2 of k*0.125 %.
module ssc_tri_walker
    import ssc_pkg::*;
#(
    parameter int QLOG2 = 4,
    localparam int LVL_W = QLOG2 + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    en_i,
    input  logic [2:0]              code_i,
    output logic                    act_en,
    output logic [2:0]              act_code,
    output logic signed [LVL_W-1:0] lvl,
    output logic                    dir_up
);
    localparam int QI = 1 << QLOG2;
    localparam logic signed [LVL_W-1:0] TOP_LVL    = LVL_W'(QI);
    localparam logic signed [LVL_W-1:0] CENTER_BOT = LVL_W'(-QI);
    localparam logic signed [LVL_W-1:0] DOWN_BOT   = LVL_W'(-2 * QI);

    logic                    en_n;
    logic [2:0]              code_n;
    logic signed [LVL_W-1:0] lvl_n;
    logic                    dir_n;
    logic                    centered;

    assign centered = (code_profile(act_code) == PROF_CENTER);

    // Next level, direction and configuration of the sweep.
    always_comb begin
        en_n   = act_en;
        code_n = act_code;
        lvl_n  = lvl;
        dir_n  = dir_up;
        if (!act_en) begin
            en_n   = en_i;
            code_n = code_i;
            lvl_n  = '0;
            dir_n  = (code_profile(code_i) == PROF_CENTER);
        end else if (step) begin
            if (dir_up) begin
                lvl_n = lvl + LVL_W'(1);
                if (centered && (lvl_n == TOP_LVL)) begin
                    dir_n = 1'b0;
                end
            end else begin
                lvl_n = lvl - LVL_W'(1);
                if (lvl_n == (centered ? CENTER_BOT : DOWN_BOT)) begin
                    dir_n = 1'b1;
                end
            end
            if (lvl_n == '0) begin
                en_n   = en_i;
                code_n = code_i;
                if (code_profile(code_i) == PROF_DOWN) begin
                    dir_n = 1'b0;
                end
            end
        end
    end

    // Register the sweep state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en   <= 1'b0;
            act_code <= 3'd0;
            lvl      <= '0;
            dir_up   <= 1'b1;
        end else begin
            act_en   <= en_n;
            act_code <= code_n;
            lvl      <= lvl_n;
            dir_up   <= dir_n;
        end
    end

endmodule

// File: rtl/ssc_offset_scale.sv
// Offset scaler: samples N, then forms N*2^FRAC_W + floor(N*lvl*k*UNIT / 2^QLOG2).
// Assumes UNIT is the fixed-point value of 0.125 % with FRAC_W fraction bits.
module ssc_offset_scale
    import ssc_pkg::*;
#(
    parameter int N_W    = 8,
    parameter int FRAC_W = 24,
    parameter int QLOG2  = 4,
    parameter int UNIT   = 20972,
    localparam int LVL_W = QLOG2 + 3,
    localparam int OUT_W = N_W + 1 + FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_W-1:0]          n_i,
    input  logic signed [LVL_W-1:0] lvl,
    input  logic [2:0]              act_code,
    output logic [OUT_W-1:0]        eff
);
    localparam int UNIT_W = $clog2(UNIT + 1);
    localparam int PW_A   = N_W + LVL_W + 4 + UNIT_W;
    localparam int PW_B   = N_W + FRAC_W + 2;
    localparam int PROD_W = (PW_A > PW_B) ? PW_A : PW_B;

    logic [N_W-1:0]           n_q;
    logic signed [PROD_W-1:0] a_n;
    logic signed [PROD_W-1:0] a_l;
    logic signed [PROD_W-1:0] a_k;
    logic signed [PROD_W-1:0] a_u;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] sum;

    // Sample the base divider once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= '0;
        end else begin
            n_q <= n_i;
        end
    end

    // Scale the level into a fixed-point offset and add the base.
    always_comb begin
        a_n  = PROD_W'(n_q);
        a_l  = {{(PROD_W - LVL_W){lvl[LVL_W-1]}}, lvl};
        a_k  = PROD_W'(code_mult(act_code));
        a_u  = PROD_W'(UNIT);
        prod = a_n * a_l * a_k * a_u;
        sum  = (a_n <<< FRAC_W) + (prod >>> QLOG2);
        eff  = OUT_W'(sum);
    end

endmodule

// File: rtl/ssc_group.sv
// One clock group: step timer, triangle walker and offset scaler in a chain.
// Assumes the shared enable and the group code arrive on the system clock.
module ssc_group #(
    parameter int N_W         = 8,
    parameter int FRAC_W      = 24,
    parameter int QLOG2       = 4,
    parameter int STEP_CYCLES = 50,
    parameter int UNIT        = 20972,
    localparam int LVL_W      = QLOG2 + 3,
    localparam int OUT_W      = N_W + 1 + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [2:0]       code_i,
    input  logic [N_W-1:0]   n_i,
    output logic [OUT_W-1:0] eff_o,
    output logic             on_o,
    output logic             up_o,
    output logic             zero_o
);
    logic                    step;
    logic                    act_en;
    logic [2:0]              act_code;
    logic signed [LVL_W-1:0] lvl;
    logic                    dir_up;

    ssc_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (act_en),
        .step  (step)
    );

    ssc_tri_walker #(.QLOG2(QLOG2)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .en_i     (en_i),
        .code_i   (code_i),
        .act_en   (act_en),
        .act_code (act_code),
        .lvl      (lvl),
        .dir_up   (dir_up)
    );

    ssc_offset_scale #(
        .N_W    (N_W),
        .FRAC_W (FRAC_W),
        .QLOG2  (QLOG2),
        .UNIT   (UNIT)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .n_i      (n_i),
        .lvl      (lvl),
        .act_code (act_code),
        .eff      (eff_o)
    );

    assign on_o   = act_en;
    assign up_o   = dir_up;
    assign zero_o = (lvl == '0);

endmodule

// File: rtl/ssc_dual.sv
// Top: GROUPS independent triangular spread generators sharing one enable.
// Assumes all inputs are synchronous to clk; group g uses slice g of each bus.
module ssc_dual #(
    parameter int GROUPS      = 2,
    parameter int N_W         = 8,
    parameter int FRAC_W      = 24,
    parameter int QLOG2       = 4,
    parameter int STEP_CYCLES = 50,
    parameter int UNIT        = 20972
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             spread_en_i,
    input  logic [3*GROUPS-1:0]              mag_code_i,
    input  logic [N_W*GROUPS-1:0]            base_n_i,
    output logic [(N_W+1+FRAC_W)*GROUPS-1:0] eff_div_o,
    output logic [GROUPS-1:0]                spread_on_o,
    output logic [GROUPS-1:0]                sweep_up_o,
    output logic [GROUPS-1:0]                at_zero_o
);
    localparam int OUT_W = N_W + 1 + FRAC_W;

    // One generator per clock group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        ssc_group #(
            .N_W         (N_W),
            .FRAC_W      (FRAC_W),
            .QLOG2       (QLOG2),
            .STEP_CYCLES (STEP_CYCLES),
            .UNIT        (UNIT)
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (spread_en_i),
            .code_i (mag_code_i[3*g +: 3]),
            .n_i    (base_n_i[N_W*g +: N_W]),
            .eff_o  (eff_div_o[OUT_W*g +: OUT_W]),
            .on_o   (spread_on_o[g]),
            .up_o   (sweep_up_o[g]),
            .zero_o (at_zero_o[g])
        );
    end

endmodule

// File: rtl/ssc_dual_chk.sv
// Checker for ssc_dual: per-group port properties, bound to the top below.
// Assumes the bind passes the top's parameters through.
module ssc_dual_chk #(
    parameter int GROUPS      = 2,
    parameter int N_W         = 8,
    parameter int FRAC_W      = 24,
    parameter int QLOG2       = 4,
    parameter int STEP_CYCLES = 50,
    parameter int UNIT        = 20972
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             spread_en_i,
    input logic [3*GROUPS-1:0]              mag_code_i,
    input logic [N_W*GROUPS-1:0]            base_n_i,
    input logic [(N_W+1+FRAC_W)*GROUPS-1:0] eff_div_o,
    input logic [GROUPS-1:0]                spread_on_o,
    input logic [GROUPS-1:0]                sweep_up_o,
    input logic [GROUPS-1:0]                at_zero_o
);
    localparam int OUT_W = N_W + 1 + FRAC_W;

    logic seen;

    // Mark that one clock out of reset has passed, so $past of inputs is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        assert_idle_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !spread_on_o[g] |-> at_zero_o[g]);

        assert_idle_nominal_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && !spread_on_o[g]) |->
            (eff_div_o[OUT_W*g +: OUT_W] == (OUT_W'($past(base_n_i[N_W*g +: N_W])) << FRAC_W)));

        assert_zero_nominal_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && at_zero_o[g]) |->
            (eff_div_o[OUT_W*g +: OUT_W] == (OUT_W'($past(base_n_i[N_W*g +: N_W])) << FRAC_W)));

        assert_start_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(spread_on_o[g]) |-> at_zero_o[g]);

        assert_stop_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(spread_on_o[g]) |-> at_zero_o[g]);
    end

endmodule

bind ssc_dual ssc_dual_chk #(
    .GROUPS      (GROUPS),
    .N_W         (N_W),
    .FRAC_W      (FRAC_W),
    .QLOG2       (QLOG2),
    .STEP_CYCLES (STEP_CYCLES),
    .UNIT        (UNIT)
) u_chk (.*);

// File: tb/ssc_dual_tb.sv
module ssc_dual_tb;
    localparam int CLK_PERIOD = 10;
    localparam int G      = 2;
    localparam int N_W    = 8;
    localparam int FRAC_W = 24;
    localparam int QLOG2  = 4;
    localparam int STEPC  = 50;
    localparam int UNIT   = 20972;
    localparam int OUT_W  = N_W + 1 + FRAC_W;
    localparam int Q      = 1 << QLOG2;
    localparam int PERIOD = 4 * Q * STEPC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [N_W-1:0] n_drv [G];
    logic [2:0]     c_drv [G];
    logic [3*G-1:0]       mag_code_i;
    logic [N_W*G-1:0]     base_n_i;
    logic [OUT_W*G-1:0]   eff_div_o;
    logic [G-1:0]         spread_on_o, sweep_up_o, at_zero_o;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;
    string ph = "R1";

    assign mag_code_i = {c_drv[1], c_drv[0]};
    assign base_n_i   = {n_drv[1], n_drv[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    ssc_dual #(.GROUPS(G), .N_W(N_W), .FRAC_W(FRAC_W), .QLOG2(QLOG2),
               .STEP_CYCLES(STEPC), .UNIT(UNIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .spread_en_i(en), .mag_code_i(mag_code_i),
        .base_n_i(base_n_i), .eff_div_o(eff_div_o), .spread_on_o(spread_on_o),
        .sweep_up_o(sweep_up_o), .at_zero_o(at_zero_o));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint nominal(input int n);
        return longint'(n) <<< FRAC_W;
    endfunction

    function automatic longint exp_eff(input int n, input int lvl, input int code);
        longint p;
        p = longint'(n) * lvl * ((code & 3) + 1) * UNIT;
        return nominal(n) + (p >>> QLOG2);
    endfunction

    function automatic longint eff_of(input int g);
        return longint'(eff_div_o[OUT_W*g +: OUT_W]);
    endfunction

    // Behavioural reference: sweep state per group.
    int m_act[G], m_code[G], m_lvl[G], m_up[G], m_cnt[G], m_n[G];

    always @(posedge clk) begin
        for (int g = 0; g < G; g++) begin
            if (!rst_n) begin
                m_act[g] = 0; m_code[g] = 0; m_lvl[g] = 0; m_up[g] = 1; m_cnt[g] = 0; m_n[g] = 0;
            end else begin
                if (m_act[g] == 0) begin
                    m_act[g] = en; m_code[g] = c_drv[g]; m_lvl[g] = 0; m_cnt[g] = 0;
                    m_up[g] = (c_drv[g] >= 4) ? 1 : 0;
                end else if (m_cnt[g] == STEPC - 1) begin
                    m_cnt[g] = 0;
                    if (m_up[g] == 1) begin
                        m_lvl[g]++;
                        if (m_code[g] >= 4 && m_lvl[g] == Q) m_up[g] = 0;
                    end else begin
                        m_lvl[g]--;
                        if (m_lvl[g] == ((m_code[g] >= 4) ? -Q : -2 * Q)) m_up[g] = 1;
                    end
                    if (m_lvl[g] == 0) begin
                        m_act[g] = en; m_code[g] = c_drv[g];
                        if (c_drv[g] < 4) m_up[g] = 0;
                    end
                end else begin
                    m_cnt[g]++;
                end
                m_n[g] = n_drv[g];
            end
        end
    end

    // Per-clock comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int g = 0; g < G; g++) begin
                longint e;
                e = exp_eff(m_n[g], m_lvl[g], m_code[g]);
                check(eff_of(g) == e, {ph, " eff_div_o (R5)"}, eff_of(g), e);
                check(spread_on_o[g] == m_act[g][0], {ph, " spread_on_o (R7)"}, spread_on_o[g], m_act[g]);
                check(sweep_up_o[g] == m_up[g][0], {ph, " sweep_up_o (R8)"}, sweep_up_o[g], m_up[g]);
                check(at_zero_o[g] == (m_lvl[g] == 0), {ph, " at_zero_o (R5)"}, at_zero_o[g], m_lvl[g] == 0);
            end
        end
    end

    longint mn[G], mx[G], prv[G];
    int chg[G];

    task automatic win_start();
        for (int g = 0; g < G; g++) begin
            mn[g] = eff_of(g); mx[g] = eff_of(g); prv[g] = eff_of(g); chg[g] = 0;
        end
    endtask

    task automatic win_run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            for (int g = 0; g < G; g++) begin
                if (eff_of(g) != prv[g]) chg[g]++;
                prv[g] = eff_of(g);
                if (eff_of(g) < mn[g]) mn[g] = eff_of(g);
                if (eff_of(g) > mx[g]) mx[g] = eff_of(g);
            end
        end
    endtask

    task automatic drive_after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        n_drv[0] = '0; n_drv[1] = '0; c_drv[0] = '0; c_drv[1] = '0;
        cmp_on = 1'b1;
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(eff_of(0) == 0, "R1 eff_div_o reset", eff_of(0), 0);
        check(spread_on_o == '0, "R1 spread_on_o reset", spread_on_o, 0);
        check(at_zero_o == '1, "R1 at_zero_o reset", at_zero_o, 3);
        check(sweep_up_o == '1, "R1 sweep_up_o reset", sweep_up_o, 3);

        // R2: idle with programmed bases
        ph = "R2";
        drive_after_edge();
        rst_n = 1'b1; n_drv[0] = 8'd150; n_drv[1] = 8'd200; c_drv[0] = 3'd1; c_drv[1] = 3'd6;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(eff_of(0) == nominal(150), "R2 idle group0 nominal", eff_of(0), nominal(150));
        check(eff_of(1) == nominal(200), "R2 idle group1 nominal", eff_of(1), nominal(200));

        // R3/R4/R8/R10: enable, two full periods
        ph = "R3";
        drive_after_edge();
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(spread_on_o == 2'b11, "R7 start on next edge", spread_on_o, 3);
        check(sweep_up_o[0] == 1'b0, "R8 down spread starts falling", sweep_up_o[0], 0);
        check(sweep_up_o[1] == 1'b1, "R8 centre spread starts rising", sweep_up_o[1], 1);
        win_start();
        win_run(2 * PERIOD);
        check(mx[0] == nominal(150), "R3 down peak is nominal", mx[0], nominal(150));
        check(mn[0] == nominal(150) - 2 * 150 * 2 * UNIT, "R3 down minimum code1", mn[0],
              nominal(150) - 2 * 150 * 2 * UNIT);
        check(mx[1] == nominal(200) + 200 * 3 * UNIT, "R4 centre maximum code6", mx[1],
              nominal(200) + 200 * 3 * UNIT);
        check(mn[1] == nominal(200) - 200 * 3 * UNIT, "R4 centre minimum code6 (R10)", mn[1],
              nominal(200) - 200 * 3 * UNIT);
        check(chg[0] == 2 * 4 * Q, "R5 step count group0", chg[0], 2 * 4 * Q);
        check(chg[1] == 2 * 4 * Q, "R5 step count group1", chg[1], 2 * 4 * Q);

        // R6: code change mid-sweep waits for zero
        ph = "R6";
        repeat (500) @(posedge clk);
        #1;
        c_drv[0] = 3'd3;
        win_start();
        win_run(2600);
        check(mn[0] == nominal(150) - 2 * 150 * 2 * UNIT, "R6 old code kept until zero", mn[0],
              nominal(150) - 2 * 150 * 2 * UNIT);
        win_start();
        win_run(PERIOD);
        check(mn[0] == nominal(150) - 2 * 150 * 4 * UNIT, "R6 new code after zero", mn[0],
              nominal(150) - 2 * 150 * 4 * UNIT);
        check(mx[0] == nominal(150), "R3 never above nominal code3", mx[0], nominal(150));
        check(mn[1] == nominal(200) - 200 * 3 * UNIT, "R10 group1 unaffected", mn[1],
              nominal(200) - 200 * 3 * UNIT);

        // R7: disable mid-sweep
        ph = "R7";
        repeat (1000) @(posedge clk);
        #1;
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(spread_on_o[0] == 1'b1, "R7 group0 still sweeping", spread_on_o[0], 1);
        repeat (PERIOD) @(posedge clk);
        @(negedge clk);
        check(spread_on_o == 2'b00, "R7 stopped at zero", spread_on_o, 0);
        check(eff_of(0) == nominal(150), "R7 nominal after stop", eff_of(0), nominal(150));

        // R9: base change while idle
        ph = "R9";
        drive_after_edge();
        n_drv[0] = 8'd100;
        @(posedge clk);
        @(negedge clk);
        check(eff_of(0) == nominal(100), "R9 new base after one edge", eff_of(0), nominal(100));
        check(eff_of(1) == nominal(200), "R10 other base untouched", eff_of(1), nominal(200));

        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule